// File: doc/BRIEF.md
# Bus-Mapped Program Counter Redirect Unit

This block sits on a processor's memory-mapped bus and lets ordinary stores change the flow of the program. It decodes a small local offset, a write strobe and a write data word. It produces a program-counter load value, a program-counter load strobe and a read-back word. The bus address decoder and the program counter register are outside the block.

A store to the direct-jump offset loads the program counter at once with the written data. This path is purely combinational and lasts exactly as long as the write strobe stays high. A store to the target offset only records a destination address, on the rising clock edge. A store to the test offset is a zero test. When the written word is zero, the program counter is loaded from the recorded destination. When the word is non-zero, nothing happens. The remaining offset is unused.

Top module: `jmpu_top`

## Requirements
- R1: After the active-low reset `rstN` is asserted, the stored target is 0. With the strobe low, `pcLoad` is 0, `pcLoadVal` is 0, and `rdData` at offset 1 is 0.
- R2: While `wrEn` is 1 and `addr` is 0, `pcLoad` is 1 and `pcLoadVal` equals `wrData` in the same cycle, with no clock edge needed.
- R3: While `wrEn` is 0, `pcLoad` is 0 and `pcLoadVal` shows the stored target. `pcLoad` falls combinationally as soon as `wrEn` falls.
- R4: A write to offset 1 (`wrEn`=1, `addr`=1) captures `wrData` as the new target on the rising clock edge. `pcLoad` stays 0 both before and after that edge.
- R5: A write to offset 2 with a non-zero `wrData` leaves `pcLoad` at 0.
- R6: A write to offset 2 with `wrData` equal to 0 sets `pcLoad` to 1 while `wrEn` is high, and `pcLoadVal` shows the stored target.
- R7: `rdData` returns the stored target when `addr` is 1 and returns 0 at offsets 0, 2 and 3.
- R8: A write to offset 3 has no effect: `pcLoad` stays 0 and the stored target keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the target register updates on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Bus write strobe for this block |
| addr | input | ADDR_W (2) | Local register offset |
| wrData | input | DATA_W (8) | Bus write data |
| pcLoadVal | output | DATA_W (8) | Value to load into the program counter |
| pcLoad | output | 1 | Program-counter load strobe |
| rdData | output | DATA_W (8) | Read-back word |

## Verification
The bench builds the block with its default 8-bit data path and 2-bit offset, so every offset is reachable. The bench writes the extreme data values 0, 128 and 255. The sequence covers:
- A target write whose old value is still visible in the same cycle.
- A zero test that follows a target change.
- Writes to the unused offset that must leave the target untouched.
- A reset in the middle of the run after a target has been stored.

// File: rtl/jmpu_pkg.sv
package jmpu_pkg;

  // Strobes passed from the decode logic to the datapath
  typedef struct packed {
    logic captureTarget; // record wrData as the new target on the next edge
    logic loadDirect;    // program counter takes wrData
    logic loadStored;    // program counter takes the stored target
    logic readTarget;    // read-back shows the stored target
  } jmpu_strobe_t;

endpackage

// File: rtl/jmpu_ctrl.sv
module jmpu_ctrl
  import jmpu_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int OFS_DIRECT = 0,
  parameter int OFS_TARGET = 1,
  parameter int OFS_TESTZ  = 2
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              dataIsZero,
  output jmpu_strobe_t      strobes
);

  localparam logic [ADDR_W-1:0] SelDirect = ADDR_W'(OFS_DIRECT);
  localparam logic [ADDR_W-1:0] SelTarget = ADDR_W'(OFS_TARGET);
  localparam logic [ADDR_W-1:0] SelTestZ  = ADDR_W'(OFS_TESTZ);

  logic hitDirect;
  logic hitTarget;
  logic hitTestZ;

  always_comb begin
    hitDirect = (addr == SelDirect);
    hitTarget = (addr == SelTarget);
    hitTestZ  = (addr == SelTestZ);
  end

  always_comb begin
    strobes               = '0;
    strobes.readTarget    = hitTarget;
    strobes.captureTarget = wrEn && hitTarget;
    strobes.loadDirect    = wrEn && hitDirect;
    strobes.loadStored    = wrEn && hitTestZ && dataIsZero;
  end

endmodule

// File: rtl/jmpu_dpath.sv
module jmpu_dpath
  import jmpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] wrData,
  input  jmpu_strobe_t      strobes,
  output logic              dataIsZero,
  output logic [DATA_W-1:0] pcLoadVal,
  output logic              pcLoad,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] targetQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      targetQ <= '0;
    end else if (strobes.captureTarget) begin
      targetQ <= wrData;
    end
  end

  always_comb dataIsZero = ~|wrData;

  always_comb begin
    pcLoad    = strobes.loadDirect || strobes.loadStored;
    pcLoadVal = strobes.loadDirect ? wrData : targetQ;
    rdData    = strobes.readTarget ? targetQ : '0;
  end

endmodule

// File: rtl/jmpu_top.sv
module jmpu_top
  import jmpu_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 2,
  parameter int OFS_DIRECT = 0,
  parameter int OFS_TARGET = 1,
  parameter int OFS_TESTZ  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] pcLoadVal,
  output logic              pcLoad,
  output logic [DATA_W-1:0] rdData
);

  jmpu_strobe_t strobes;
  logic         dataIsZero;

  jmpu_ctrl #(
    .ADDR_W    (ADDR_W),
    .OFS_DIRECT(OFS_DIRECT),
    .OFS_TARGET(OFS_TARGET),
    .OFS_TESTZ (OFS_TESTZ)
  ) u_ctrl (
    .wrEn      (wrEn),
    .addr      (addr),
    .dataIsZero(dataIsZero),
    .strobes   (strobes)
  );

  jmpu_dpath #(
    .DATA_W(DATA_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .wrData    (wrData),
    .strobes   (strobes),
    .dataIsZero(dataIsZero),
    .pcLoadVal (pcLoadVal),
    .pcLoad    (pcLoad),
    .rdData    (rdData)
  );

endmodule

// File: rtl/jmpu_checker.sv
module jmpu_checker #(
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 2,
  parameter int OFS_DIRECT = 0,
  parameter int OFS_TARGET = 1,
  parameter int OFS_TESTZ  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] pcLoadVal,
  input logic              pcLoad,
  input logic [DATA_W-1:0] rdData
);

  localparam logic [ADDR_W-1:0] ADirect = ADDR_W'(OFS_DIRECT);
  localparam logic [ADDR_W-1:0] ATarget = ADDR_W'(OFS_TARGET);
  localparam logic [ADDR_W-1:0] ATestZ  = ADDR_W'(OFS_TESTZ);

  AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADirect) |-> (pcLoad && pcLoadVal == wrData)); // R2

  AST_IDLE_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !pcLoad); // R3

  AST_TARGET_WRITE_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ATarget) |-> !pcLoad); // R4

  AST_TARGET_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ATarget) |=> ((addr == ATarget) -> (rdData == $past(wrData)))); // R4

  AST_NONZERO_TEST_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ATestZ && wrData != '0) |-> !pcLoad); // R5

  AST_ZERO_TEST_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ATestZ && wrData == '0) |-> pcLoad); // R6

  AST_READ_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (addr != ATarget) |-> (rdData == '0)); // R7

  AST_TARGET_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!(wrEn && addr == ATarget) && addr == ATarget) |=> ((addr == ATarget) -> $stable(rdData))); // R8

  AST_UNUSED_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr != ADirect && addr != ATarget && addr != ATestZ) |-> !pcLoad); // R8

endmodule

bind jmpu_top jmpu_checker #(
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .OFS_DIRECT(OFS_DIRECT),
  .OFS_TARGET(OFS_TARGET),
  .OFS_TESTZ (OFS_TESTZ)
) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .addr     (addr),
  .wrData   (wrData),
  .pcLoadVal(pcLoadVal),
  .pcLoad   (pcLoad),
  .rdData   (rdData)
);

// File: tb/jmpu_top_bench.sv
module jmpu_top_bench;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int NVEC   = 14;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] pcLoadVal;
  logic              pcLoad;
  logic [DATA_W-1:0] rdData;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  jmpu_top u_jmpu_top (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .addr     (addr),
    .wrData   (wrData),
    .pcLoadVal(pcLoadVal),
    .pcLoad   (pcLoad),
    .rdData   (rdData)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  ofs;
    logic [7:0]  data;
    logic        expLoad;
    logic [7:0]  expVal;
    logic [7:0]  expRd;
    logic [15:0] tag;
  } vec_t;

  // Each vector is applied after a rising edge and checked before the next one.
  // The expected outputs reflect the target stored before that next edge.
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 2'd0, 8'd0,   1'b0, 8'd0,   8'd0,   "R3"}, // idle, target 0
    '{1'b1, 2'd0, 8'd123, 1'b1, 8'd123, 8'd0,   "R2"}, // direct jump
    '{1'b1, 2'd1, 8'd212, 1'b0, 8'd0,   8'd0,   "R4"}, // target write, old value still visible
    '{1'b0, 2'd1, 8'd0,   1'b0, 8'd212, 8'd212, "R7"}, // read back target
    '{1'b1, 2'd2, 8'd1,   1'b0, 8'd212, 8'd0,   "R5"}, // non-zero test
    '{1'b1, 2'd2, 8'd0,   1'b1, 8'd212, 8'd0,   "R6"}, // zero test jumps
    '{1'b1, 2'd3, 8'd0,   1'b0, 8'd212, 8'd0,   "R8"}, // unused offset
    '{1'b1, 2'd3, 8'd77,  1'b0, 8'd212, 8'd0,   "R8"}, // unused offset
    '{1'b0, 2'd1, 8'd0,   1'b0, 8'd212, 8'd212, "R8"}, // target unchanged
    '{1'b1, 2'd0, 8'd255, 1'b1, 8'd255, 8'd0,   "R2"}, // direct jump max value
    '{1'b1, 2'd1, 8'd5,   1'b0, 8'd212, 8'd212, "R4"}, // new target, old value shown
    '{1'b0, 2'd2, 8'd0,   1'b0, 8'd5,   8'd0,   "R3"}, // no strobe, no jump
    '{1'b1, 2'd2, 8'd0,   1'b1, 8'd5,   8'd0,   "R6"}, // zero test uses new target
    '{1'b1, 2'd2, 8'd128, 1'b0, 8'd5,   8'd0,   "R5"}  // top bit only
  };

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag, input logic expLoad,
                          input logic [7:0] expVal, input logic [7:0] expRd);
    check(tag, "pcLoad", {7'd0, pcLoad}, {7'd0, expLoad});
    check(tag, "pcLoadVal", pcLoadVal, expVal);
    check(tag, "rdData", rdData, expRd);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: state during and after reset
    repeat (3) @(posedge clk);
    #2;
    addr = 2'd1;
    #1 checkAll("R1", 1'b0, 8'd0, 8'd0);
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    checkAll("R1", 1'b0, 8'd0, 8'd0);

    for (int i = 0; i < NVEC; i++) begin
      @(posedge clk); #1;
      wrEn   = VECS[i].wr;
      addr   = VECS[i].ofs;
      wrData = VECS[i].data;
      @(negedge clk);
      checkAll(string'(VECS[i].tag), VECS[i].expLoad, VECS[i].expVal, VECS[i].expRd);
    end

    // R3: strobe falls combinationally, mid-cycle
    @(posedge clk); #1;
    wrEn = 1'b1; addr = 2'd0; wrData = 8'd42;
    #1 check("R3", "pcLoad high", {7'd0, pcLoad}, 8'd1);
    wrEn = 1'b0;
    #1 check("R3", "pcLoad dropped", {7'd0, pcLoad}, 8'd0);
    check("R3", "pcLoadVal idle", pcLoadVal, 8'd5);

    // R4: strobe stays low after the capture edge while write still held
    @(posedge clk); #1;
    wrEn = 1'b1; addr = 2'd1; wrData = 8'd99;
    @(posedge clk); #1;
    check("R4", "pcLoad after edge", {7'd0, pcLoad}, 8'd0);
    check("R4", "rdData captured", rdData, 8'd99);
    wrEn = 1'b0;

    // R7: read at offset 0 returns 0 with a non-zero target
    addr = 2'd0;
    #1 check("R7", "rdData ofs0", rdData, 8'd0);
    addr = 2'd3;
    #1 check("R7", "rdData ofs3", rdData, 8'd0);

    // R1: reset mid-run clears the stored target
    @(posedge clk); #1 rstN = 1'b0;
    addr = 2'd1;
    #1 checkAll("R1", 1'b0, 8'd0, 8'd0);
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    checkAll("R1", 1'b0, 8'd0, 8'd0);

    // R6: zero test after reset jumps to target 0
    @(posedge clk); #1;
    wrEn = 1'b1; addr = 2'd2; wrData = 8'd0;
    @(negedge clk);
    checkAll("R6", 1'b1, 8'd0, 8'd0);
    @(posedge clk); #1 wrEn = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule